// File: doc/BRIEF.md
# Multi-Mode 15 kHz CRT Timing Generator

This block turns a 27 MHz video clock into the raster timing for a standard-definition CRT. It supplies active-low horizontal and vertical sync, a blanking flag, the coordinates of the current active pixel, a pixel clock enable and an interlace field flag. It has three rasters: a 352-pixel-wide, 240-line progressive raster at 60 Hz, a 720-pixel-wide interlaced raster at 60 Hz with 240 lines in each field, and a 352-pixel-wide, 288-line progressive raster at 50 Hz.

Software-facing logic upstream drives a two-bit raster select and two signed centring trims. The block clamps the trims and adopts the select and the trims only when one field ends and the next begins, so the raster never changes shape in the middle of a field. In the interlaced raster the field flag changes when vertical blanking starts, so a line fetcher that preloads during blanking already sees the parity of the field about to be drawn.

The vertical active and total line counts are parameters. Their default values give the broadcast rasters.

Top module: `crt_timing_gen`

## Requirements
- R1: `pix_en` is high for one clock in every 4 clocks in the progressive rasters (select 00, 10, 11) and for one clock in every 2 clocks in the interlaced raster (select 01).
- R2: The line period is 1716 clocks in both 60 Hz rasters (429 enables times 4, or 858 enables times 2) and 1728 clocks in the 50 Hz raster (432 enables times 4).
- R3: `blank` is low only inside the active area. The active area is 352 enables per line in the progressive rasters and 720 in the interlaced raster, with `active_x` running from 0 up to width−1. Each frame or field has 240, 240 or 288 active lines by default, set by parameters.
- R4: `hsync_n` is low for 32 enables (progressive) or 62 enables (interlaced). It falls (FP − htrim) enables after the last active pixel of a line, where FP is 14 in the progressive rasters and 16 in the interlaced raster.
- R5: `vsync_n` is low for 3 lines, which all lie inside vertical blanking. It falls at the start of line (active lines + 4 − vtrim), with lines counted from 0. By default a frame is 262 lines at 60 Hz progressive and 312 lines at 50 Hz.
- R6: In the interlaced raster, fields of parity 0 have the parameter length (262 by default) and fields of parity 1 have one line more. The vsync of a parity-1 field starts 429 enables (half a line) later in its line, so both vsync-to-vsync intervals are 262.5 lines.
- R7: In the interlaced raster, `field` toggles when the line counter enters the first blank line. The toggle comes (858 − 720) enables after the last active pixel of the field. `active_y` is 2·line + field in the interlaced raster and equals the line number in the progressive rasters.
- R8: `field` stays 0 in the progressive rasters.
- R9: The horizontal trim is saturated to −8..+8 and the vertical trim to −8..+2 before use. Inputs outside these ranges act as the nearest limit.
- R10: The raster select and the trims are adopted only at the end of the last enable of a frame or field, and also while reset is held. A change in the middle of a field has no effect until the next field begins.
- R11: Select code 00 is 240p60, 01 is 480i60, 10 is 288p50, and 11 behaves as 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz video clock |
| rst_n | input | 1 | Synchronous active-low reset; loads select and trims |
| mode_sel | input | 2 | Raster select (R11 encoding) |
| h_trim | input | TRIM_W | Signed horizontal centring trim, in pixel enables |
| v_trim | input | TRIM_W | Signed vertical centring trim, in lines |
| pix_en | output | 1 | Pixel clock enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the active area |
| field | output | 1 | Interlace field flag |
| active_x | output | 10 | Pixel column, valid while blank is low |
| active_y | output | 10 | Active line, woven in interlaced mode |
| | | | |

## Verification
A wrong divider or a wrong horizontal total shows within one line: the pixel enable spacing or the hsync-to-hsync time is off by whole enables. A wrong vertical count, trim or latch state shows only at the next vsync or at the first active pixel of the next field, so the bench measures these in absolute clocks from one vsync to the next. A parity error in the interlaced raster breaks the 262.5-line symmetry between adjacent vsyncs and gives a wrong woven `active_y` on the first active line of the next field.

// File: rtl/crt_timing_gen.sv
module crt_timing_gen #(
  parameter int TRIM_W     = 6,
  parameter int LINES_240P = 240,
  parameter int FRAME_240P = 262,
  parameter int LINES_480I = 240,
  parameter int FIELD_480I = 262,
  parameter int LINES_288P = 288,
  parameter int FRAME_288P = 312
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_sel,
  input  logic signed [TRIM_W-1:0] h_trim,
  input  logic signed [TRIM_W-1:0] v_trim,
  output logic                     pix_en,
  output logic                     hsync_n,
  output logic                     vsync_n,
  output logic                     blank,
  output logic                     field,
  output logic [9:0]               active_x,
  output logic [9:0]               active_y
);
  localparam int CW        = 10;
  localparam int H_LIM     = 8;
  localparam int V_LO      = -8;
  localparam int V_HI      = 2;
  localparam int V_PORCH   = 4;
  localparam int V_SYNC    = 3;

  function automatic logic signed [4:0] sat(input logic signed [TRIM_W-1:0] t, input int lo, input int hi);
    int v;
    v = int'(t);
    if (v < lo) v = lo;
    else if (v > hi) v = hi;
    return 5'(v);
  endfunction

  logic [1:0]        div, mode_q;
  logic [CW-1:0]     hcnt, vcnt;
  logic signed [4:0] ht_q, vt_q;
  logic              armed;
  logic              ilace, tall, line_end, frame_end, in_hs, in_vs;
  int                h_act, h_tot, h_fp, h_sw, v_act, v_tot, hs0, vs0, vs_off, h, v;

  assign ilace = (mode_q == 2'b01);
  assign tall  = (mode_q == 2'b10);

  always_comb begin
    h     = int'(hcnt);
    v     = int'(vcnt);
    h_act = ilace ? 720 : 352;
    h_tot = ilace ? 858 : (tall ? 432 : 429);
    h_fp  = ilace ? 16 : 14;
    h_sw  = ilace ? 62 : 32;
    v_act = ilace ? LINES_480I : (tall ? LINES_288P : LINES_240P);
    v_tot = ilace ? (field ? FIELD_480I : FIELD_480I + 1) : (tall ? FRAME_288P : FRAME_240P);
    hs0   = h_act + h_fp - int'(ht_q);
    vs0   = v_act + V_PORCH - int'(vt_q);
    vs_off = (ilace && !field) ? h_tot / 2 : 0;
    in_hs = (h >= hs0) && (h < hs0 + h_sw);
    in_vs = ((v > vs0) || (v == vs0 && h >= vs_off)) &&
            ((v < vs0 + V_SYNC) || (v == vs0 + V_SYNC && h < vs_off));
  end

  assign pix_en    = (div == 2'd0);
  assign line_end  = pix_en && (h == h_tot - 1);
  assign frame_end = line_end && (v == v_tot - 1);
  assign hsync_n   = ~in_hs;
  assign vsync_n   = ~in_vs;
  assign blank     = !((h < h_act) && (v < v_act));
  assign active_x  = hcnt;
  assign active_y  = ilace ? {vcnt[CW-2:0], field} : vcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div    <= 2'd0;
      hcnt   <= '0;
      vcnt   <= '0;
      field  <= 1'b0;
      armed  <= 1'b0;
      mode_q <= mode_sel;
      ht_q   <= sat(h_trim, -H_LIM, H_LIM);
      vt_q   <= sat(v_trim, V_LO, V_HI);
    end else begin
      armed <= 1'b1;
      div   <= (div == (ilace ? 2'd1 : 2'd3)) ? 2'd0 : div + 2'd1;
      if (pix_en) begin
        if (!line_end) begin
          hcnt <= hcnt + 1'b1;
        end else begin
          hcnt <= '0;
          if (frame_end) begin
            vcnt   <= '0;
            mode_q <= mode_sel;
            ht_q   <= sat(h_trim, -H_LIM, H_LIM);
            vt_q   <= sat(v_trim, V_LO, V_HI);
            if (mode_sel != 2'b01) field <= 1'b0;
          end else begin
            vcnt <= vcnt + 1'b1;
            if (ilace && v == v_act - 1) field <= ~field;
          end
        end
      end
    end
  end

  AST_PIX_GAP: assert property (@(posedge clk) disable iff (!rst_n) pix_en |=> !pix_en); // R1
  AST_PROG_FIELD: assert property (@(posedge clk) disable iff (!rst_n) !ilace |-> !field); // R8
  AST_TRIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (int'(ht_q) >= -H_LIM) && (int'(ht_q) <= H_LIM) && (int'(vt_q) >= V_LO) && (int'(vt_q) <= V_HI)); // R9
  AST_HOLD_MIDFIELD: assert property (@(posedge clk) disable iff (!rst_n) !frame_end |=> ($stable(mode_q) && $stable(ht_q) && $stable(vt_q))); // R10
  AST_FIELD_AT_VBLANK: assert property (@(posedge clk) disable iff (!rst_n) (armed && ilace && (field != $past(field))) |-> (hcnt == '0 && v == v_act)); // R7
  AST_VSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n) !vsync_n |-> blank); // R5
endmodule

// File: tb/test_crt_timing_gen.sv
module test_crt_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ACT = 2;
  localparam int TOT = 18;
  localparam int WATCHDOG = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic signed [5:0] h_trim = '0;
  logic signed [5:0] v_trim = '0;
  logic pix_en, hsync_n, vsync_n, blank, field;
  logic [9:0] active_x, active_y;

  crt_timing_gen #(
    .TRIM_W(6), .LINES_240P(ACT), .FRAME_240P(TOT), .LINES_480I(ACT),
    .FIELD_480I(TOT), .LINES_288P(ACT), .FRAME_288P(TOT)
  ) i_crt_timing_gen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .h_trim(h_trim), .v_trim(v_trim),
    .pix_en(pix_en), .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .field(field),
    .active_x(active_x), .active_y(active_y)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampv(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic logic probe(input int sel);
    case (sel)
      0: return hsync_n;
      1: return vsync_n;
      2: return blank;
      3: return pix_en;
      default: return field;
    endcase
  endfunction

  task automatic wait_to(input int sel, input logic val, output int t, output int last_x);
    logic p;
    do begin
      p = probe(sel);
      last_x = int'(active_x);
      @(negedge clk);
    end while (!(p != val && probe(sel) == val));
    t = cyc;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d cycles", WATCHDOG, 0);
    summary();
    $finish;
  end

  initial begin
    int t1, t2, tr, th, tu, tf, tv1, tv2, ta, tb, x, hA, vA, hB, vB, hC, vC, vsA, vsB, vsC, tva, tvb, tvc, tfl;
    void'($urandom(32'd2718));

    // Phase A: 240p, directed over-range htrim, random vtrim
    vA = int'($urandom_range(9, 0)) - 5;
    h_trim = 6'(20);
    v_trim = 6'(vA);
    hA = clampv(20, -8, 8);
    vA = clampv(vA, -8, 2);
    vsA = ACT + 4 - vA;
    mode_sel = 2'b00;
    repeat (4) @(negedge clk);
    chk("R3 reset hsync_n", int'(hsync_n), 1);
    chk("R5 reset vsync_n", int'(vsync_n), 1);
    chk("R8 reset field", int'(field), 0);
    chk("R3 reset active_x", int'(active_x), 0);
    rst_n = 1'b1;

    wait_to(3, 1'b1, t1, x);
    wait_to(3, 1'b1, t2, x);
    chk("R1 pix_en spacing 240p", t2 - t1, 4);
    wait_to(2, 1'b1, tr, x);
    chk("R3 last active x 240p", x, 351);
    wait_to(0, 1'b0, t1, x);
    chk("R4 R9 hsync offset clamped +8", t1 - tr, (14 - hA) * 4);
    wait_to(0, 1'b1, tu, x);
    chk("R4 hsync width 240p", tu - t1, 32 * 4);
    wait_to(2, 1'b0, tf, x);
    chk("R3 first active x", int'(active_x), 0);
    chk("R7 active_y progressive", int'(active_y), 1);
    chk("R8 field progressive", int'(field), 0);
    wait_to(2, 1'b1, tr, x);
    chk("R3 active width 240p", tr - tf, 352 * 4);
    wait_to(0, 1'b0, th, x);
    chk("R2 line period 240p", th - t1, 1716);
    wait_to(1, 1'b0, tv1, x);
    chk("R5 vsync line 240p", tv1 - tr, (429 - 352) * 4 + (vsA - ACT) * 1716);
    chk("R5 vsync inside blank", int'(blank), 1);
    wait_to(1, 1'b1, tu, x);
    chk("R5 vsync width", tu - tv1, 3 * 1716);

    // mid-frame change: 288p, directed under-range htrim, over-range vtrim
    mode_sel = 2'b10;
    h_trim = 6'(-25);
    v_trim = 6'(6);
    hB = clampv(-25, -8, 8);
    vB = clampv(6, -8, 2);
    vsB = ACT + 4 - vB;
    wait_to(0, 1'b0, ta, x);
    wait_to(0, 1'b0, tb, x);
    chk("R10 mode held mid-frame", tb - ta, 1716);
    wait_to(2, 1'b0, tf, x);
    chk("R5 frame total 240p", tf - tv1, (TOT - vsA) * 1716);
    chk("R3 frame start y", int'(active_y), 0);
    wait_to(2, 1'b1, tr, x);
    chk("R3 active width 288p", tr - tf, 352 * 4);
    chk("R3 last active x 288p", x, 351);
    wait_to(0, 1'b0, t1, x);
    chk("R9 R10 hsync offset clamped -8", t1 - tr, (14 - hB) * 4);
    wait_to(0, 1'b0, t2, x);
    chk("R2 R11 line period 288p", t2 - t1, 1728);
    wait_to(1, 1'b0, tv2, x);
    chk("R10 vsync interval across switch", tv2 - tv1, (TOT - vsA) * 1716 + vsB * 1728);

    // code 11 behaves as 240p
    mode_sel = 2'b11;
    h_trim = 6'(0);
    wait_to(2, 1'b0, tf, x);
    chk("R5 frame total 288p", tf - tv2, (TOT - vsB) * 1728);
    wait_to(3, 1'b1, t1, x);
    wait_to(3, 1'b1, t2, x);
    chk("R11 pix_en spacing code 11", t2 - t1, 4);
    wait_to(0, 1'b0, t1, x);
    wait_to(0, 1'b0, t2, x);
    chk("R11 line period code 11", t2 - t1, 1716);
    chk("R8 field code 11", int'(field), 0);

    // Phase B: 480i with random trims
    @(negedge clk);
    rst_n = 1'b0;
    hC = int'($urandom_range(24, 0)) - 12;
    vC = int'($urandom_range(9, 0)) - 5;
    mode_sel = 2'b01;
    h_trim = 6'(hC);
    v_trim = 6'(vC);
    hC = clampv(hC, -8, 8);
    vC = clampv(vC, -8, 2);
    vsC = ACT + 4 - vC;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    wait_to(3, 1'b1, t1, x);
    wait_to(3, 1'b1, t2, x);
    chk("R1 pix_en spacing 480i", t2 - t1, 2);
    wait_to(2, 1'b1, tr, x);
    chk("R3 last active x 480i", x, 719);
    wait_to(0, 1'b0, t1, x);
    chk("R4 hsync offset 480i", t1 - tr, (16 - hC) * 2);
    wait_to(0, 1'b1, tu, x);
    chk("R4 hsync width 480i", tu - t1, 62 * 2);
    wait_to(2, 1'b0, tf, x);
    chk("R7 woven y line1 field0", int'(active_y), 2);
    wait_to(2, 1'b1, tr, x);
    chk("R3 active width 480i", tr - tf, 720 * 2);
    wait_to(0, 1'b0, th, x);
    chk("R2 line period 480i", th - t1, 1716);
    wait_to(4, 1'b1, tfl, x);
    chk("R7 field flips at vblank start", tfl - tr, (858 - 720) * 2);
    wait_to(1, 1'b0, tva, x);
    chk("R5 vsync line field0", tva - tfl, (vsC - ACT) * 1716);
    chk("R7 field during vblank", int'(field), 1);
    wait_to(2, 1'b0, tf, x);
    chk("R6 even field length", tf - tva, (TOT - vsC) * 1716);
    chk("R7 woven y field1 start", int'(active_y), 1);
    wait_to(1, 1'b0, tvb, x);
    chk("R6 vsync interval even->odd", tvb - tva, (2 * TOT + 1) * 858);
    chk("R7 field after odd vblank", int'(field), 0);
    wait_to(2, 1'b0, tf, x);
    chk("R6 odd field length and half-line", tf - tvb, (TOT + 1 - vsC) * 1716 - 858);
    chk("R7 woven y field0 start", int'(active_y), 0);
    wait_to(1, 1'b0, tvc, x);
    chk("R6 vsync interval odd->even", tvc - tvb, (2 * TOT + 1) * 858);

    summary();
    $finish;
  end
endmodule